// File: doc/BRIEF.md
# Page Program and Erase Sequencer

This block sits behind a serial memory front-end and turns a decoded program or erase command into a self-timed operation on the storage array. For a program command it gathers the incoming data bytes into a page-sized staging buffer. The buffer position follows the start offset and wraps inside the addressed page. When chip select is released on a byte boundary and the protection logic grants permission, the block copies every buffered byte into the array and holds a busy flag for a fixed number of clock cycles.

The same timer runs the three erase variants: one page, one sector, or the entire array. Each erase is issued to the array as a single strobe that carries a scope code and an aligned base address. When any timed operation ends, the busy flag drops. In that same cycle the block raises a one-cycle request to clear the write enable latch.

All durations are parameters counted in system clock cycles.

Top module: `page_commit_engine`

## Requirements
- R1: After reset, `wip`, `clearWel`, `arrWrEn` and `arrEraseEn` are all 0.
- R2: A program session is opened by `cmdStart` with `cmdKind`=0. Each `dataValid` byte is stored at the current page offset. A commit drives one `arrWrEn` beat for each offset that received a byte, and no beat for any other offset. The beats come in ascending offset order, each at address {page of `startAddr`, offset}.
- R3: The offset starts at `startAddr` bits [7:0] and advances by one per byte. After 0xFF it wraps to 0x00 of the same page. A later byte at an offset replaces the earlier one.
- R4: A `csRise` with `csBitsMod8` not equal to 0 abandons the session: no array strobe follows and `wip` stays 0.
- R5: A `csRise` in a program session that has received no data byte abandons the session, with no array strobe and `wip` staying 0.
- R6: A `csRise` while `permit` is 0 abandons the session, with no array strobe and `wip` staying 0.
- R7: After a committing `csRise`, `wip` is 1 from the next cycle for exactly WRITE_CYCLES cycles for a program, or for PAGE_ERASE_CYCLES, SECTOR_ERASE_CYCLES or CHIP_ERASE_CYCLES cycles for an erase.
- R8: `clearWel` is 1 for exactly one cycle: the first cycle in which `wip` is 0 after a timed operation. It is 0 at all other times.
- R9: A page erase (`cmdKind`=1) issues one `arrEraseEn` beat, in the first `wip` cycle, with `arrEraseScope`=0 and `arrAddr` equal to `startAddr` with bits [7:0] cleared.
- R10: A sector erase (`cmdKind`=2) issues one `arrEraseEn` beat with `arrEraseScope`=1 and `arrAddr` equal to `startAddr` with bits [SECTOR_BITS-1:0] cleared (32 KiB sectors by default).
- R11: A chip erase (`cmdKind`=3) issues one `arrEraseEn` beat with `arrEraseScope`=2 and `arrAddr`=0.
- R12: While `wip` is 1, `cmdStart`, `dataValid` and `csRise` are ignored. No later array strobe results from them, and `wip` still falls on schedule.
- R13: `arrWrEn` is 1 only while `wip` is 1. `arrWrEn` and `arrEraseEn` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmdStart | input | 1 | One-cycle pulse: a program or erase command with its address has been decoded |
| cmdKind | input | 2 | Operation: 0 program, 1 page erase, 2 sector erase, 3 chip erase |
| startAddr | input | ADDR_W | Byte address carried by the command |
| dataValid | input | 1 | One-cycle pulse: `dataByte` holds a received data byte |
| dataByte | input | 8 | Received data byte |
| csRise | input | 1 | One-cycle pulse: chip select has been released |
| csBitsMod8 | input | 3 | Bits clocked in the transaction, modulo 8, at release |
| permit | input | 1 | Protection logic allows the pending operation |
| wip | output | 1 | Timed operation in progress |
| clearWel | output | 1 | One-cycle request to clear the write enable latch |
| arrWrEn | output | 1 | Array byte write strobe |
| arrWrData | output | 8 | Byte to write |
| arrEraseEn | output | 1 | Array erase strobe |
| arrEraseScope | output | 2 | Erase extent: 0 page, 1 sector, 2 chip |
| arrAddr | output | ADDR_W | Write address, or aligned erase base |

## Verification
The assertions check, on every cycle, the invariants that need no stimulus history. Write strobes appear only inside a busy window, and a write never coincides with an erase. Consecutive write beats stay in one page. An erase beat appears only in the first busy cycle and carries a properly aligned base. The latch-clear pulse coincides exactly with the fall of the busy flag, and each busy window has one of the configured lengths. Whether the written data match the received bytes, whether wrapped bytes overwrite earlier ones, and whether each abandon condition suppresses the commit can only be shown by the bench's scenarios. The same holds for whether the length fits the operation and for whether commands arriving during a busy window are really discarded. The bench compares the array port against a scoreboard of expected writes and erases.

// File: rtl/page_commit_pkg.sv
`timescale 1ns/1ps
package page_commit_pkg;

  typedef enum logic [1:0] {
    KIND_WRITE        = 2'd0,
    KIND_PAGE_ERASE   = 2'd1,
    KIND_SECTOR_ERASE = 2'd2,
    KIND_CHIP_ERASE   = 2'd3
  } opKind_t;

  typedef enum logic [1:0] {
    SCOPE_PAGE   = 2'd0,
    SCOPE_SECTOR = 2'd1,
    SCOPE_CHIP   = 2'd2
  } eraseScope_t;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_BUSY    = 2'd2
  } seqState_t;

  // Strobes from the sequencer to the staging datapath
  typedef struct packed {
    logic openSession;  // latch address, clear the page buffer
    logic takeByte;     // store dataByte at current offset
    logic drainStep;    // present buffer lane drainIdx to the array
    logic fireErase;    // issue the erase beat for the held kind
  } seqStrobe_t;

endpackage

// File: rtl/page_commit_ctrl.sv
`timescale 1ns/1ps
module page_commit_ctrl
  import page_commit_pkg::*;
#(
  parameter int PAGE_BITS           = 8,
  parameter int WRITE_CYCLES        = 400,
  parameter int PAGE_ERASE_CYCLES   = 300,
  parameter int SECTOR_ERASE_CYCLES = 500,
  parameter int CHIP_ERASE_CYCLES   = 700
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmdStart,
  input  opKind_t              cmdKind,
  input  logic                 dataValid,
  input  logic                 csRise,
  input  logic [2:0]           csBitsMod8,
  input  logic                 permit,
  input  logic                 gotData,
  output seqStrobe_t           strobe,
  output opKind_t              kindQ,
  output logic [PAGE_BITS-1:0] drainIdx,
  output logic                 wip,
  output logic                 clearWel
);

  localparam int MAX_A   = (WRITE_CYCLES > PAGE_ERASE_CYCLES) ? WRITE_CYCLES : PAGE_ERASE_CYCLES;
  localparam int MAX_B   = (SECTOR_ERASE_CYCLES > CHIP_ERASE_CYCLES) ? SECTOR_ERASE_CYCLES : CHIP_ERASE_CYCLES;
  localparam int MAX_DUR = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_DUR + 1);

  seqState_t        state;
  logic [CNT_W-1:0] durCnt;
  logic [PAGE_BITS:0] drainCnt;
  logic             clearWelQ;
  logic             aligned;
  logic             commitOk;
  logic             acceptStart;

  function automatic logic [CNT_W-1:0] loadFor(opKind_t k);
    case (k)
      KIND_WRITE:        return CNT_W'(WRITE_CYCLES - 1);
      KIND_PAGE_ERASE:   return CNT_W'(PAGE_ERASE_CYCLES - 1);
      KIND_SECTOR_ERASE: return CNT_W'(SECTOR_ERASE_CYCLES - 1);
      default:           return CNT_W'(CHIP_ERASE_CYCLES - 1);
    endcase
  endfunction

  always_comb begin
    aligned     = (csBitsMod8 == 3'd0);
    commitOk    = (state == ST_COLLECT) && csRise && aligned && permit &&
                  ((kindQ != KIND_WRITE) || gotData);
    acceptStart = cmdStart &&
                  ((state == ST_IDLE) || ((state == ST_COLLECT) && !csRise));
    strobe             = '0;
    strobe.openSession = acceptStart;
    strobe.takeByte    = (state == ST_COLLECT) && dataValid && !csRise &&
                         (kindQ == KIND_WRITE) && !acceptStart;
    strobe.drainStep   = (state == ST_BUSY) && (kindQ == KIND_WRITE) &&
                         !drainCnt[PAGE_BITS];
    strobe.fireErase   = commitOk && (kindQ != KIND_WRITE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      kindQ     <= KIND_WRITE;
      durCnt    <= '0;
      drainCnt  <= '0;
      clearWelQ <= 1'b0;
    end else begin
      clearWelQ <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (cmdStart) begin
            state <= ST_COLLECT;
            kindQ <= cmdKind;
          end
        end
        ST_COLLECT: begin
          if (csRise) begin
            if (commitOk) begin
              state    <= ST_BUSY;
              durCnt   <= loadFor(kindQ);
              drainCnt <= '0;
            end else begin
              state <= ST_IDLE;
            end
          end else if (cmdStart) begin
            kindQ <= cmdKind;
          end
        end
        ST_BUSY: begin
          if (strobe.drainStep) drainCnt <= drainCnt + 1'b1;
          if (durCnt == '0) begin
            state     <= ST_IDLE;
            clearWelQ <= 1'b1;
          end else begin
            durCnt <= durCnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign drainIdx = drainCnt[PAGE_BITS-1:0];
  assign wip      = (state == ST_BUSY);
  assign clearWel = clearWelQ;

endmodule

// File: rtl/page_commit_dp.sv
`timescale 1ns/1ps
module page_commit_dp
  import page_commit_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int PAGE_BITS   = 8,
  parameter int SECTOR_BITS = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  seqStrobe_t           strobe,
  input  opKind_t              kindQ,
  input  logic [ADDR_W-1:0]    startAddr,
  input  logic [7:0]           dataByte,
  input  logic [PAGE_BITS-1:0] drainIdx,
  output logic                 gotData,
  output logic                 arrWrEn,
  output logic [7:0]           arrWrData,
  output logic                 arrEraseEn,
  output logic [1:0]           arrEraseScope,
  output logic [ADDR_W-1:0]    arrAddr
);

  localparam int PAGE_BYTES = 1 << PAGE_BITS;
  localparam logic [ADDR_W-1:0] PAGE_MASK   = {ADDR_W{1'b1}} << PAGE_BITS;
  localparam logic [ADDR_W-1:0] SECTOR_MASK = {ADDR_W{1'b1}} << SECTOR_BITS;

  logic [ADDR_W-1:0]    sessionAddr;
  logic [PAGE_BITS-1:0] ptr;
  logic [7:0]           laneData [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] laneValid;

  // Session address, offset pointer and data-seen flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sessionAddr <= '0;
      ptr         <= '0;
      gotData     <= 1'b0;
    end else if (strobe.openSession) begin
      sessionAddr <= startAddr;
      ptr         <= startAddr[PAGE_BITS-1:0];
      gotData     <= 1'b0;
    end else if (strobe.takeByte) begin
      ptr     <= ptr + 1'b1;   // natural wrap keeps the offset inside the page
      gotData <= 1'b1;
    end
  end

  // One staging lane per page offset
  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        laneValid[i] <= 1'b0;
        laneData[i]  <= 8'h00;
      end else if (strobe.openSession) begin
        laneValid[i] <= 1'b0;
      end else if (strobe.takeByte && (ptr == PAGE_BITS'(i))) begin
        laneValid[i] <= 1'b1;
        laneData[i]  <= dataByte;
      end
    end
  end

  // Registered array port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arrWrEn       <= 1'b0;
      arrWrData     <= 8'h00;
      arrEraseEn    <= 1'b0;
      arrEraseScope <= SCOPE_PAGE;
      arrAddr       <= '0;
    end else begin
      arrWrEn    <= strobe.drainStep && laneValid[drainIdx];
      arrEraseEn <= strobe.fireErase;
      if (strobe.fireErase) begin
        case (kindQ)
          KIND_PAGE_ERASE: begin
            arrEraseScope <= SCOPE_PAGE;
            arrAddr       <= sessionAddr & PAGE_MASK;
          end
          KIND_SECTOR_ERASE: begin
            arrEraseScope <= SCOPE_SECTOR;
            arrAddr       <= sessionAddr & SECTOR_MASK;
          end
          default: begin
            arrEraseScope <= SCOPE_CHIP;
            arrAddr       <= '0;
          end
        endcase
      end else if (strobe.drainStep) begin
        arrWrData <= laneData[drainIdx];
        arrAddr   <= (sessionAddr & PAGE_MASK) |
                     {{(ADDR_W-PAGE_BITS){1'b0}}, drainIdx};
      end
    end
  end

endmodule

// File: rtl/page_commit_engine.sv
`timescale 1ns/1ps
module page_commit_engine
  import page_commit_pkg::*;
#(
  parameter int ADDR_W              = 17,
  parameter int PAGE_BITS           = 8,
  parameter int SECTOR_BITS         = 15,
  parameter int WRITE_CYCLES        = 400,
  parameter int PAGE_ERASE_CYCLES   = 300,
  parameter int SECTOR_ERASE_CYCLES = 500,
  parameter int CHIP_ERASE_CYCLES   = 700
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmdStart,
  input  logic [1:0]        cmdKind,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              dataValid,
  input  logic [7:0]        dataByte,
  input  logic              csRise,
  input  logic [2:0]        csBitsMod8,
  input  logic              permit,
  output logic              wip,
  output logic              clearWel,
  output logic              arrWrEn,
  output logic [7:0]        arrWrData,
  output logic              arrEraseEn,
  output logic [1:0]        arrEraseScope,
  output logic [ADDR_W-1:0] arrAddr
);

  seqStrobe_t           strobe;
  opKind_t              kindQ;
  logic [PAGE_BITS-1:0] drainIdx;
  logic                 gotData;

  page_commit_ctrl #(
    .PAGE_BITS(PAGE_BITS),
    .WRITE_CYCLES(WRITE_CYCLES),
    .PAGE_ERASE_CYCLES(PAGE_ERASE_CYCLES),
    .SECTOR_ERASE_CYCLES(SECTOR_ERASE_CYCLES),
    .CHIP_ERASE_CYCLES(CHIP_ERASE_CYCLES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmdStart(cmdStart), .cmdKind(opKind_t'(cmdKind)),
    .dataValid(dataValid), .csRise(csRise), .csBitsMod8(csBitsMod8),
    .permit(permit), .gotData(gotData),
    .strobe(strobe), .kindQ(kindQ), .drainIdx(drainIdx),
    .wip(wip), .clearWel(clearWel)
  );

  page_commit_dp #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .SECTOR_BITS(SECTOR_BITS)
  ) u_dp (
    .clk(clk), .rst_n(rst_n),
    .strobe(strobe), .kindQ(kindQ), .startAddr(startAddr),
    .dataByte(dataByte), .drainIdx(drainIdx), .gotData(gotData),
    .arrWrEn(arrWrEn), .arrWrData(arrWrData),
    .arrEraseEn(arrEraseEn), .arrEraseScope(arrEraseScope), .arrAddr(arrAddr)
  );

endmodule

// File: rtl/page_commit_chk.sv
`timescale 1ns/1ps
module page_commit_chk #(
  parameter int ADDR_W              = 17,
  parameter int PAGE_BITS           = 8,
  parameter int SECTOR_BITS         = 15,
  parameter int WRITE_CYCLES        = 400,
  parameter int PAGE_ERASE_CYCLES   = 300,
  parameter int SECTOR_ERASE_CYCLES = 500,
  parameter int CHIP_ERASE_CYCLES   = 700
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wip,
  input logic              clearWel,
  input logic              arrWrEn,
  input logic              arrEraseEn,
  input logic [1:0]        arrEraseScope,
  input logic [ADDR_W-1:0] arrAddr
);

  int unsigned busyLen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   busyLen <= 0;
    else if (wip) busyLen <= busyLen + 1;
    else          busyLen <= 0;
  end

  a_r13_write_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    arrWrEn |-> wip);

  a_r13_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(arrWrEn && arrEraseEn));

  a_r3_same_page: assert property (@(posedge clk) disable iff (!rst_n)
    (arrWrEn && $past(arrWrEn)) |->
      (arrAddr[ADDR_W-1:PAGE_BITS] == $past(arrAddr[ADDR_W-1:PAGE_BITS])));

  a_r8_clear_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    clearWel |-> (!wip && $past(wip)));

  a_r8_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> clearWel);

  a_r9_erase_first_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    arrEraseEn |-> (wip && !$past(wip)));

  a_r9_page_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (arrEraseEn && arrEraseScope == 2'd0) |-> (arrAddr[PAGE_BITS-1:0] == '0));

  a_r10_sector_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (arrEraseEn && arrEraseScope == 2'd1) |-> (arrAddr[SECTOR_BITS-1:0] == '0));

  a_r11_chip_base: assert property (@(posedge clk) disable iff (!rst_n)
    (arrEraseEn && arrEraseScope == 2'd2) |-> (arrAddr == '0));

  a_r7_window_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> (busyLen == WRITE_CYCLES || busyLen == PAGE_ERASE_CYCLES ||
                    busyLen == SECTOR_ERASE_CYCLES || busyLen == CHIP_ERASE_CYCLES));

endmodule

bind page_commit_engine page_commit_chk #(
  .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .SECTOR_BITS(SECTOR_BITS),
  .WRITE_CYCLES(WRITE_CYCLES), .PAGE_ERASE_CYCLES(PAGE_ERASE_CYCLES),
  .SECTOR_ERASE_CYCLES(SECTOR_ERASE_CYCLES), .CHIP_ERASE_CYCLES(CHIP_ERASE_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wip(wip), .clearWel(clearWel),
  .arrWrEn(arrWrEn), .arrEraseEn(arrEraseEn),
  .arrEraseScope(arrEraseScope), .arrAddr(arrAddr)
);

// File: tb/page_commit_engine_tb.sv
`timescale 1ns/1ps
module page_commit_engine_tb;

  localparam int ADDR_W  = 17;
  localparam int WR_CYC  = 400;
  localparam int PE_CYC  = 300;
  localparam int SE_CYC  = 500;
  localparam int CE_CYC  = 700;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmdStart = 1'b0;
  logic [1:0]        cmdKind = 2'd0;
  logic [ADDR_W-1:0] startAddr = '0;
  logic              dataValid = 1'b0;
  logic [7:0]        dataByte = 8'h00;
  logic              csRise = 1'b0;
  logic [2:0]        csBitsMod8 = 3'd0;
  logic              permit = 1'b1;
  logic              wip, clearWel, arrWrEn, arrEraseEn;
  logic [7:0]        arrWrData;
  logic [1:0]        arrEraseScope;
  logic [ADDR_W-1:0] arrAddr;

  page_commit_engine #(
    .ADDR_W(ADDR_W), .WRITE_CYCLES(WR_CYC), .PAGE_ERASE_CYCLES(PE_CYC),
    .SECTOR_ERASE_CYCLES(SE_CYC), .CHIP_ERASE_CYCLES(CE_CYC)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cmdStart(cmdStart), .cmdKind(cmdKind),
    .startAddr(startAddr), .dataValid(dataValid), .dataByte(dataByte),
    .csRise(csRise), .csBitsMod8(csBitsMod8), .permit(permit),
    .wip(wip), .clearWel(clearWel), .arrWrEn(arrWrEn), .arrWrData(arrWrData),
    .arrEraseEn(arrEraseEn), .arrEraseScope(arrEraseScope), .arrAddr(arrAddr)
  );

  always #2 clk = ~clk;

  typedef struct {
    bit                isErase;
    logic [1:0]        scope;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        data;
    string             tag;
  } expItem_t;

  expItem_t expQ[$];
  int total = 0;
  int fails = 0;
  int lastRun = 0;
  int runCnt = 0;
  bit prevWip = 1'b0;
  bit doneFlag = 1'b0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: array port against the scoreboard, busy window and latch-clear
  always @(negedge clk) begin
    if (rst_n) begin
      if (arrWrEn || arrEraseEn) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R2/R12 unexpected array strobe", longint'(arrAddr), 0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(arrEraseEn == e.isErase, {e.tag, " strobe kind"}, arrEraseEn, e.isErase);
          check(arrAddr == e.addr, {e.tag, " address"}, arrAddr, e.addr);
          if (e.isErase) check(arrEraseScope == e.scope, {e.tag, " scope"}, arrEraseScope, e.scope);
          else           check(arrWrData == e.data, {e.tag, " data"}, arrWrData, e.data);
        end
        if (arrWrEn) check(wip == 1'b1, "R13 write outside busy", wip, 1);
      end
      if (wip) runCnt++;
      else if (prevWip) begin
        lastRun  = runCnt;
        runCnt   = 0;
        doneFlag = 1'b1;
        check(clearWel == 1'b1, "R8 clear missing at busy fall", clearWel, 1);
      end
      if (clearWel && !(prevWip && !wip))
        check(1'b0, "R8 stray clear pulse", clearWel, 0);
      prevWip = wip;
    end
  end

  task automatic openCmd(input logic [1:0] k, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    cmdStart = 1'b1; cmdKind = k; startAddr = a;
    @(negedge clk);
    cmdStart = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    dataValid = 1'b1; dataByte = b;
    @(negedge clk);
    dataValid = 1'b0;
  endtask

  task automatic raiseCs(input logic [2:0] bits, input logic perm);
    @(negedge clk);
    csRise = 1'b1; csBitsMod8 = bits; permit = perm;
    @(negedge clk);
    csRise = 1'b0; csBitsMod8 = 3'd0; permit = 1'b1;
  endtask

  // Stream n bytes from addr, model the page pointer, queue expected writes
  task automatic loadWrite(input logic [ADDR_W-1:0] a, input int n, input logic [7:0] seed, input string tag);
    logic [7:0] img [256];
    bit         vld [256];
    logic [7:0] p;
    for (int i = 0; i < 256; i++) vld[i] = 1'b0;
    openCmd(2'd0, a);
    p = a[7:0];
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = seed ^ 8'(i * 13);
      sendByte(b);
      img[p] = b; vld[p] = 1'b1;
      p = p + 8'd1;
    end
    for (int i = 0; i < 256; i++) begin
      if (vld[i]) begin
        expItem_t e;
        e.isErase = 1'b0; e.scope = 2'd0; e.data = img[i]; e.tag = tag;
        e.addr = {a[ADDR_W-1:8], 8'(i)};
        expQ.push_back(e);
      end
    end
  endtask

  task automatic waitDone(input int expLen, input string tag);
    int guard = 0;
    while (!doneFlag && guard < 5000) begin @(negedge clk); guard++; end
    check(doneFlag, {tag, " busy window ended"}, doneFlag, 1);
    check(lastRun == expLen, {tag, " busy length"}, lastRun, expLen);
    check(expQ.size() == 0, {tag, " all expected strobes seen"}, expQ.size(), 0);
    doneFlag = 1'b0;
  endtask

  task automatic expectIdle(input string tag);
    repeat (30) @(negedge clk);
    check(wip == 1'b0, {tag, " busy stays low"}, wip, 0);
    check(doneFlag == 1'b0, {tag, " no busy window"}, doneFlag, 0);
    check(expQ.size() == 0, {tag, " queue empty"}, expQ.size(), 0);
  endtask

  task automatic queueErase(input logic [1:0] sc, input logic [ADDR_W-1:0] a, input string tag);
    expItem_t e;
    e.isErase = 1'b1; e.scope = sc; e.addr = a; e.data = 8'h00; e.tag = tag;
    expQ.push_back(e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check(wip == 0, "R1 wip", wip, 0);
    check(clearWel == 0, "R1 clearWel", clearWel, 0);
    check(arrWrEn == 0, "R1 arrWrEn", arrWrEn, 0);
    check(arrEraseEn == 0, "R1 arrEraseEn", arrEraseEn, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: short write inside a page
    loadWrite(17'h00310, 3, 8'h3C, "R2");
    raiseCs(3'd0, 1'b1);
    waitDone(WR_CYC, "R7 write");

    // R3: wrap across the page end
    loadWrite(17'h001FE, 4, 8'hA1, "R3 wrap");
    raiseCs(3'd0, 1'b1);
    waitDone(WR_CYC, "R3 wrap");

    // R3: 257 bytes, last overwrites offset 0
    loadWrite(17'h00500, 257, 8'h5A, "R3 overwrite");
    raiseCs(3'd0, 1'b1);
    waitDone(WR_CYC, "R3 overwrite");

    // R4: misaligned release
    openCmd(2'd0, 17'h00400);
    sendByte(8'h11); sendByte(8'h22);
    raiseCs(3'd3, 1'b1);
    expectIdle("R4");

    // R5: release with no data
    openCmd(2'd0, 17'h00400);
    raiseCs(3'd0, 1'b1);
    expectIdle("R5");

    // R6: permission withheld
    openCmd(2'd0, 17'h00400);
    sendByte(8'h33);
    raiseCs(3'd0, 1'b0);
    expectIdle("R6");
    openCmd(2'd1, 17'h00400);
    raiseCs(3'd0, 1'b0);
    expectIdle("R6 erase");

    // R9: page erase
    openCmd(2'd1, 17'h1A3C5);
    queueErase(2'd0, 17'h1A300, "R9");
    raiseCs(3'd0, 1'b1);
    waitDone(PE_CYC, "R9");

    // R10: sector erase
    openCmd(2'd2, 17'h1A3C5);
    queueErase(2'd1, 17'h18000, "R10");
    raiseCs(3'd0, 1'b1);
    waitDone(SE_CYC, "R10");

    // R11: chip erase
    openCmd(2'd3, 17'h0ABCD);
    queueErase(2'd2, 17'h00000, "R11");
    raiseCs(3'd0, 1'b1);
    waitDone(CE_CYC, "R11");

    // R12: traffic during a busy window is discarded
    loadWrite(17'h00600, 1, 8'h77, "R12");
    raiseCs(3'd0, 1'b1);
    repeat (5) @(negedge clk);
    check(wip == 1'b1, "R12 busy started", wip, 1);
    openCmd(2'd0, 17'h00700);
    sendByte(8'h99);
    raiseCs(3'd0, 1'b1);
    openCmd(2'd3, 17'h00000);
    raiseCs(3'd0, 1'b1);
    waitDone(WR_CYC, "R12");
    expectIdle("R12 after");

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule